// File: doc/BRIEF.md
# Prioritized External Chip-Select Decoder

This block turns a 24-bit bus address into four active-low pin values for external memory devices. Each of the four channels holds a base address, a window-size code and an enable bit. A channel claims an access when the address bits above its window boundary equal the same bits of its base. An internal-memory window sits in front of all channels. When windows overlap, a fixed priority decides which channel wins, so at most one select goes low.

When fewer channels are enabled, the pins of the unused channels are reassigned to carry high address bits A16 to A19. This lets a larger external memory be addressed through the same four pins. The pin values and an internal-hit flag are registered on the bus clock. Bus timing, address latching and the external address path are handled elsewhere.

Top module: `csdec_top`

## Requirements
- R1: Outputs are registered. A new address and strobe show on the pins one clock after they are sampled. While reset is low (asynchronous, active low), all pins read 1 and int_hit reads 0.
- R2: A channel's window spans 2^n bytes, where n = 8 + its size code. The channel matches when bus_addr[23:n] equals its base[23:n]. Base bits below n are ignored.
- R3: Size codes 0 to 16 are valid (256 B to 16 MB). A channel with a code above 16 never asserts its select. The pin assignment still follows the enable bits.
- R4: An address below int_limit with the strobe high sets int_hit, and no chip select asserts. An address equal to int_limit is not internal.
- R5: Priority when windows overlap: internal first, then channel 0, 1, 2, 3. At most one chip select is low per access.
- R6: With the strobe low, every chip-select pin reads 1 and int_hit reads 0.
- R7: A channel whose enable bit (ch_enable[i] for channel i) is clear never asserts, even when its base matches.
- R8: With ch_enable = 4'b1111, pin i is channel i's select. With 4'b1110, pin 0 carries A16 and pins 3..1 are selects.
- R9: With ch_enable = 4'b1100, pin 1 carries A17 and pin 0 carries A16, regardless of the strobe.
- R10: With ch_enable = 4'b1000, pins 3..0 carry A19..A16 regardless of the strobe. Channel 3 still decodes but has no pin.
- R11: With any other enable pattern, every pin is its channel's select, and the pin of a disabled channel stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Access address |
| bus_strobe | input | 1 | Access in progress |
| int_limit | input | 24 | Addresses below this value are internal |
| ch_base | input | 96 | Channel bases, channel i in bits [24i+23:24i] |
| ch_size | input | 20 | Size codes, channel i in bits [5i+4:5i] |
| ch_enable | input | 4 | Channel enables, bit i for channel i |
| cs_pin_n | output | 4 | Pin values: active-low selects or address bits |
| int_hit | output | 1 | Registered internal-window hit |

## Verification
On every cycle, the checker enforces the following:
- a single low select in the full-select configuration;
- silent selects without a strobe;
- no external select beside an internal hit;
- the pin-to-address routing in the reduced configurations.

Only the bench scenarios can show the rest:
- which channel wins a particular overlap;
- that base bits below the window edge are ignored;
- the exact int_limit boundary;
- that an out-of-range size code silences a channel;
- the one-cycle output latency.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int ADDR_W    = 24;
    localparam int NUM_CH    = 4;
    localparam int SZ_W      = 5;
    localparam int MIN_SHIFT = 8;

    typedef enum logic [2:0] {
        PM_ALL_CS,
        PM_HI16,
        PM_HI17,
        PM_HI19,
        PM_SPARSE
    } pin_mode_e;
endpackage

// File: rtl/csd_window.sv
module csd_window #(
    parameter int ADDR_W    = 24,
    parameter int SZ_W      = 5,
    parameter int MIN_SHIFT = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_code,
    input  logic              enable,
    output logic              hit
);
    localparam int MAX_CODE = ADDR_W - MIN_SHIFT;

    logic [SZ_W:0]       shamt;
    logic [ADDR_W-1:0]   keep_mask;
    logic                code_ok;

    always_comb begin
        code_ok   = ({1'b0, size_code} <= (SZ_W+1)'(MAX_CODE));
        shamt     = {1'b0, size_code} + (SZ_W+1)'(MIN_SHIFT);
        keep_mask = {ADDR_W{1'b1}} << shamt;
        hit       = enable && code_ok && (((addr ^ base) & keep_mask) == '0);
    end
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] ch_hit,
    input  logic              blocked,
    output logic [NUM_CH-1:0] grant
);
    always_comb begin
        logic taken;
        taken = blocked;
        grant = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!taken && ch_hit[i]) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/csd_pinmap.sv
module csd_pinmap
    import csd_pkg::*;
(
    input  logic [3:0] enable,
    input  logic [3:0] grant,
    input  logic [3:0] addr_hi,
    output logic [3:0] pins_n
);
    pin_mode_e mode;

    always_comb begin
        unique case (enable)
            4'b1111: mode = PM_ALL_CS;
            4'b1110: mode = PM_HI16;
            4'b1100: mode = PM_HI17;
            4'b1000: mode = PM_HI19;
            default: mode = PM_SPARSE;
        endcase
    end

    always_comb begin
        unique case (mode)
            PM_ALL_CS: pins_n = ~grant;
            PM_HI16:   pins_n = {~grant[3:1], addr_hi[0]};
            PM_HI17:   pins_n = {~grant[3:2], addr_hi[1:0]};
            PM_HI19:   pins_n = addr_hi;
            default:   pins_n = ~grant;
        endcase
    end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_strobe,
    input  logic [ADDR_W-1:0]        int_limit,
    input  logic [NUM_CH*ADDR_W-1:0] ch_base,
    input  logic [NUM_CH*SZ_W-1:0]   ch_size,
    input  logic [NUM_CH-1:0]        ch_enable,
    output logic [NUM_CH-1:0]        cs_pin_n,
    output logic                     int_hit
);
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] pins_d;
    logic              int_in;
    logic              blocked;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_win
        csd_window #(
            .ADDR_W   (ADDR_W),
            .SZ_W     (SZ_W),
            .MIN_SHIFT(MIN_SHIFT)
        ) win_i (
            .addr     (bus_addr),
            .base     (ch_base[g*ADDR_W +: ADDR_W]),
            .size_code(ch_size[g*SZ_W +: SZ_W]),
            .enable   (ch_enable[g]),
            .hit      (ch_hit[g])
        );
    end

    always_comb begin
        int_in  = bus_addr < int_limit;
        blocked = !bus_strobe || int_in;
    end

    csd_prio #(.NUM_CH(NUM_CH)) prio_i (
        .ch_hit (ch_hit),
        .blocked(blocked),
        .grant  (grant)
    );

    csd_pinmap map_i (
        .enable (ch_enable),
        .grant  (grant),
        .addr_hi(bus_addr[19:16]),
        .pins_n (pins_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pin_n <= '1;
            int_hit  <= 1'b0;
        end else begin
            cs_pin_n <= pins_d;
            int_hit  <= bus_strobe && int_in;
        end
    end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk
    import csd_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_strobe,
    input logic [ADDR_W-1:0]        int_limit,
    input logic [NUM_CH*ADDR_W-1:0] ch_base,
    input logic [NUM_CH*SZ_W-1:0]   ch_size,
    input logic [NUM_CH-1:0]        ch_enable,
    input logic [NUM_CH-1:0]        cs_pin_n,
    input logic                     int_hit
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R5
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ch_enable) == 4'b1111) |-> ($countones(~cs_pin_n) <= 1));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ch_enable) == 4'b1111 && !$past(bus_strobe))
            |-> (cs_pin_n == 4'b1111 && !int_hit));

    // R4
    internal_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && int_hit && $past(ch_enable) == 4'b1111) |-> (cs_pin_n == 4'b1111));

    // R4
    internal_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && int_hit) |-> $past(bus_strobe));

    // R10
    four_addr_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ch_enable) == 4'b1000) |-> (cs_pin_n == $past(bus_addr[19:16])));

    // R9
    two_addr_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ch_enable) == 4'b1100) |-> (cs_pin_n[1:0] == $past(bus_addr[17:16])));

    // R7
    none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ch_enable) == 4'b0000) |-> (cs_pin_n == 4'b1111));
endmodule

bind csdec_top csdec_chk chk_i (.*);

// File: tb/csdec_tb.sv
module csdec_top_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  en;
        logic [23:0] addr;
        logic        stb;
        logic [3:0]  pins;
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    // Fixed setup: ch0 base 0x1ABCDE code 12 (1MB, low bits ignored), ch1 0x200000 code 13,
    // ch2 0x300000 code 0 (inside ch1), ch3 0x000000 code 16 (catch-all), int_limit 0x001000
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 24'h000800, 1'b1, 4'hF, 1'b1, 4'd4},   // R4 internal
        '{4'hF, 24'h150000, 1'b1, 4'hE, 1'b0, 4'd2},   // R2 ch0, base low bits ignored
        '{4'hF, 24'h250000, 1'b1, 4'hD, 1'b0, 4'd8},   // R8 ch1
        '{4'hF, 24'h300010, 1'b1, 4'hD, 1'b0, 4'd5},   // R5 ch1 beats ch2
        '{4'hF, 24'h800000, 1'b1, 4'h7, 1'b0, 4'd5},   // R5 ch3 catch-all
        '{4'hF, 24'h150000, 1'b0, 4'hF, 1'b0, 4'd6},   // R6 no strobe
        '{4'hD, 24'h300010, 1'b1, 4'hB, 1'b0, 4'd7},   // R7 ch1 off, ch2 wins
        '{4'hE, 24'h150000, 1'b1, 4'h7, 1'b0, 4'd8},   // R8 pin0=A16=1
        '{4'hE, 24'h240000, 1'b1, 4'hC, 1'b0, 4'd8},   // R8 pin0=A16=0
        '{4'hC, 24'h820000, 1'b0, 4'hE, 1'b0, 4'd9},   // R9 address pins without strobe
        '{4'hC, 24'h310000, 1'b1, 4'h5, 1'b0, 4'd9},   // R9 ch3 plus A17/A16
        '{4'h8, 24'h0A0000, 1'b1, 4'hA, 1'b0, 4'd10},  // R10
        '{4'h8, 24'h050000, 1'b0, 4'h5, 1'b0, 4'd10},  // R10 no strobe
        '{4'h0, 24'h150000, 1'b1, 4'hF, 1'b0, 4'd7},   // R7 all off
        '{4'hF, 24'h000FFF, 1'b1, 4'hF, 1'b1, 4'd4},   // R4 last internal byte
        '{4'hF, 24'h001000, 1'b1, 4'h7, 1'b0, 4'd4},   // R4 limit is external
        '{4'h5, 24'h150000, 1'b1, 4'hE, 1'b0, 4'd11}   // R11 sparse pattern
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = 24'h150000;
    logic        bus_strobe = 1'b1;
    logic [23:0] int_limit = 24'h001000;
    logic [95:0] ch_base = {24'h000000, 24'h300000, 24'h200000, 24'h1ABCDE};
    logic [19:0] ch_size = {5'd16, 5'd0, 5'd13, 5'd12};
    logic [3:0]  ch_enable = 4'hF;
    logic [3:0]  cs_pin_n;
    logic        int_hit;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .int_limit(int_limit), .ch_base(ch_base), .ch_size(ch_size),
        .ch_enable(ch_enable), .cs_pin_n(cs_pin_n), .int_hit(int_hit)
    );

    task automatic check(input int req, input logic [3:0] ep, input logic eh);
        n_checks++;
        if (cs_pin_n !== ep || int_hit !== eh) begin
            n_fail++;
            $display("FAIL R%0d: pins=%b hit=%b expected pins=%b hit=%b",
                     req, cs_pin_n, int_hit, ep, eh);
        end
    endtask

    task automatic apply(input logic [3:0] en, input logic [23:0] a, input logic s);
        @(negedge clk);
        ch_enable  = en;
        bus_addr   = a;
        bus_strobe = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1 reset state with an active access pending
        repeat (3) @(posedge clk);
        #1;
        check(1, 4'hF, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].en, VECS[i].addr, VECS[i].stb);
            check(int'(VECS[i].req), VECS[i].pins, VECS[i].hit);
        end

        // R1 latency: new address not visible before the next edge
        apply(4'hF, 24'h800000, 1'b1);
        @(negedge clk);
        bus_addr = 24'h150000;
        #1;
        check(1, 4'h7, 1'b0);
        @(posedge clk);
        #1;
        check(1, 4'hE, 1'b0);

        // R3 invalid size code silences ch0; ch3 catches the access
        @(negedge clk);
        ch_size[4:0] = 5'd17;
        apply(4'hF, 24'h150000, 1'b1);
        check(3, 4'h7, 1'b0);
        @(negedge clk);
        ch_size[4:0] = 5'd12;
        apply(4'hF, 24'h150000, 1'b1);
        check(3, 4'hE, 1'b0);

        // R1 asynchronous reset in mid-access
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, 4'hF, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(4'hF, 24'h000100, 1'b1);
        check(4, 4'hF, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule